// File: doc/BRIEF.md
# Audio Master-Clock Selector and Voice Divider

This block produces the internal master clocks of an audio codec with two clock domains: a hi-fi path (hi-fi DAC) and a voice path (record ADC and voice DAC). The hi-fi clock is picked from an external hi-fi clock input or from a first PLL output. The voice clock is picked from an external voice clock input or from a second PLL output. A share bit can instead tie the voice path to the hi-fi clock. The record ADC and the voice DAC always take one common clock, `voice_clk`.

The voice clock also feeds a programmable divider. Its ratio code selects bypass or a division by 2, 3, 4, 6 or 8, and one code selects an average ratio of 5.5. That ratio is made on rising edges only, by alternating output periods of 5 and 6 input cycles. A new ratio takes effect only when the current output period ends, so no short pulse appears. Two general-purpose pads each carry either a functional output from elsewhere in the chip or a clock. Pad A can carry the hi-fi clock and pad B the divided voice clock.

All settings are held in one control register, written through a plain write strobe on the system clock. The block has no streaming data, so there is no valid/ready interface. Every pin is a plain control or clock pin.

Top module: `audio_clk_sel`

## Requirements
- R1: After reset the control register holds 0x20. So the hi-fi clock follows `ext_hifi_clk`, `voice_clk` equals the hi-fi clock, the divider is bypassed, and both pads carry their functional inputs.
- R2: A write with `wr_en`=1 and `wr_addr` equal to CTRL_ADDR (default 3) loads `wr_data` into the control register at the next `clk` rising edge. The field layout is [2:0] ratio code, [3] hi-fi source, [4] voice source, [5] share, [6] pad A clock, [7] pad B clock. A write to any other address leaves every output unchanged.
- R3: The hi-fi source bit selects the hi-fi clock: 0 gives `ext_hifi_clk` and 1 gives `pll_a_clk`.
- R4: When the share bit is 1, `voice_clk` equals the hi-fi clock. When it is 0, the voice source bit selects the clock: 0 gives `ext_voice_clk` and 1 gives `pll_b_clk`.
- R5: The ratio code sets the period of `voice_div_clk` in `voice_clk` cycles: 000 and 001 give 1 (the output is `voice_clk` itself), 100 gives 2, 010 gives 3, 101 gives 4, 110 gives 6 and 111 gives 8.
- R6: For a divide-by-N code the output is high for floor(N/2) input cycles. The even ratios therefore run at 50% duty, and divide-by-3 stays high for 1 cycle.
- R7: Code 011 gives output periods that alternate between 5 and 6 input cycles, with high times of 2 and 3 cycles respectively.
- R8: After a ratio change, every output pulse has the full high and low time of either the old ratio or the new one.
- R9: When its pad bit is 1, pad A carries the hi-fi clock and pad B carries `voice_div_clk`. When its pad bit is 0, each pad follows its functional input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the control register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_data | input | 8 | Register write data |
| ext_hifi_clk | input | 1 | External hi-fi clock candidate |
| pll_a_clk | input | 1 | First PLL output candidate |
| ext_voice_clk | input | 1 | External voice clock candidate |
| pll_b_clk | input | 1 | Second PLL output candidate |
| func_a | input | 1 | Functional output for pad A |
| func_b | input | 1 | Functional output for pad B |
| hifi_clk | output | 1 | Hi-fi DAC master clock |
| voice_clk | output | 1 | Shared record ADC / voice DAC master clock |
| voice_div_clk | output | 1 | Divided voice clock |
| pad_a | output | 1 | Pad A driver |
| pad_b | output | 1 | Pad B driver |

## Verification
The divider assertions are clocked by `voice_clk`. They assume that this clock has no runt pulses and that a new ratio code stays stable for at least the synchronizer depth before it is used. To keep within this, the stimulus writes the register only from the system clock domain and changes the clock selection only between measurements. It also measures periods only after several output edges, once the synchronizer and the current period have settled. Reset is released at an instant that coincides with no edge of any candidate clock.

// File: rtl/acs_pkg.sv
`timescale 1ns/1ps
package acs_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 4;
  localparam int CTRL_W = 8;
  localparam int NUM_PADS = 2;

  typedef logic [CODE_W-1:0] ratio_code_t;

  localparam ratio_code_t CODE_BYPASS = 3'b000;
  localparam ratio_code_t CODE_SPARE  = 3'b001;
  localparam ratio_code_t CODE_DIV3   = 3'b010;
  localparam ratio_code_t CODE_DIV5P5 = 3'b011;
  localparam ratio_code_t CODE_DIV2   = 3'b100;
  localparam ratio_code_t CODE_DIV4   = 3'b101;
  localparam ratio_code_t CODE_DIV6   = 3'b110;
  localparam ratio_code_t CODE_DIV8   = 3'b111;

  typedef struct packed {
    logic        pad_b_clk;
    logic        pad_a_clk;
    logic        share;
    logic        voice_pll;
    logic        hifi_pll;
    ratio_code_t ratio;
  } acs_ctrl_t;

  localparam acs_ctrl_t CTRL_RESET = '{pad_b_clk: 1'b0, pad_a_clk: 1'b0,
                                       share: 1'b1, voice_pll: 1'b0,
                                       hifi_pll: 1'b0, ratio: CODE_BYPASS};

  // Output period in input cycles; long_ph picks 6 over 5 for the 5.5 code.
  function automatic logic [CNT_W-1:0] period_len(ratio_code_t c, logic long_ph);
    logic [CNT_W-1:0] len;
    case (c)
      CODE_DIV3:   len = CNT_W'(3);
      CODE_DIV5P5: len = long_ph ? CNT_W'(6) : CNT_W'(5);
      CODE_DIV2:   len = CNT_W'(2);
      CODE_DIV4:   len = CNT_W'(4);
      CODE_DIV6:   len = CNT_W'(6);
      CODE_DIV8:   len = CNT_W'(8);
      default:     len = CNT_W'(1);
    endcase
    return len;
  endfunction

  function automatic logic is_bypass(ratio_code_t c);
    return (c == CODE_BYPASS) || (c == CODE_SPARE);
  endfunction
endpackage

// File: rtl/acs_ctrl_reg.sv
`timescale 1ns/1ps
module acs_ctrl_reg
  import acs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  output acs_ctrl_t         ctrl
);
  logic hit;
  assign hit = wr_en && (wr_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ctrl <= CTRL_RESET;
    else if (hit) ctrl <= acs_ctrl_t'(wr_data);
  end

  // R2
  addr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != CTRL_ADDR)) |=> $stable(ctrl));

  // R2
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (ctrl == $past(wr_data)));
endmodule

// File: rtl/acs_clk_mux.sv
`timescale 1ns/1ps
module acs_clk_mux
  import acs_pkg::*;
(
  input  acs_ctrl_t            ctrl,
  input  logic                 ext_hifi_clk,
  input  logic                 pll_a_clk,
  input  logic                 ext_voice_clk,
  input  logic                 pll_b_clk,
  input  logic                 div_clk,
  input  logic [NUM_PADS-1:0]  pad_func,
  output logic                 hifi_clk,
  output logic                 voice_clk,
  output logic [NUM_PADS-1:0]  pad_out
);
  logic own_voice;
  logic [NUM_PADS-1:0] pad_src;
  logic [NUM_PADS-1:0] pad_sel;

  assign hifi_clk  = ctrl.hifi_pll  ? pll_a_clk : ext_hifi_clk;
  assign own_voice = ctrl.voice_pll ? pll_b_clk : ext_voice_clk;
  assign voice_clk = ctrl.share     ? hifi_clk  : own_voice;

  assign pad_src = {div_clk, hifi_clk};
  assign pad_sel = {ctrl.pad_b_clk, ctrl.pad_a_clk};

  generate
    for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
      assign pad_out[g] = pad_sel[g] ? pad_src[g] : pad_func[g];
    end
  endgenerate
endmodule

// File: rtl/acs_frac_div.sv
`timescale 1ns/1ps
module acs_frac_div
  import acs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_in,
  input  logic        rst_n,
  input  ratio_code_t code_in,
  output logic        clk_out
);
  ratio_code_t      sync_q [SYNC_STAGES];
  ratio_code_t      code_s;
  ratio_code_t      cur_code, nxt_code;
  logic [CNT_W-1:0] cnt, nxt_cnt, cur_len, nxt_hi;
  logic             long_ph, nxt_long;
  logic             at_end;
  logic             out_q, out_d;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= CODE_BYPASS;
    end else begin
      sync_q[0] <= code_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end
  assign code_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    cur_len = period_len(cur_code, long_ph);
    at_end  = (cnt == cur_len - 1'b1);
    if (at_end) begin
      nxt_code = code_s;
      nxt_long = (code_s == CODE_DIV5P5) && (cur_code == CODE_DIV5P5) && !long_ph;
      nxt_cnt  = '0;
    end else begin
      nxt_code = cur_code;
      nxt_long = long_ph;
      nxt_cnt  = cnt + 1'b1;
    end
    nxt_hi = period_len(nxt_code, nxt_long) >> 1;
    out_d  = (nxt_cnt < nxt_hi);
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cur_code <= CODE_BYPASS;
      cnt      <= '0;
      long_ph  <= 1'b0;
      out_q    <= 1'b0;
    end else begin
      cur_code <= nxt_code;
      cnt      <= nxt_cnt;
      long_ph  <= nxt_long;
      out_q    <= out_d;
    end
  end

  assign clk_out = is_bypass(cur_code) ? clk_in : out_q;

  // R8
  code_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !at_end |=> $stable(cur_code));

  // R5
  cnt_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt < period_len(cur_code, long_ph));

  // R6
  rise_start_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(out_q) |-> (cnt == '0));

  // R7
  alt_len_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (at_end && cur_code == CODE_DIV5P5 && code_s == CODE_DIV5P5) |=> (long_ph != $past(long_ph)));
endmodule

// File: rtl/audio_clk_sel.sv
`timescale 1ns/1ps
module audio_clk_sel
  import acs_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              ext_hifi_clk,
  input  logic              pll_a_clk,
  input  logic              ext_voice_clk,
  input  logic              pll_b_clk,
  input  logic              func_a,
  input  logic              func_b,
  output logic              hifi_clk,
  output logic              voice_clk,
  output logic              voice_div_clk,
  output logic              pad_a,
  output logic              pad_b
);
  acs_ctrl_t           ctrl;
  logic [NUM_PADS-1:0] pads;

  acs_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl    (ctrl)
  );

  acs_clk_mux u_mux (
    .ctrl          (ctrl),
    .ext_hifi_clk  (ext_hifi_clk),
    .pll_a_clk     (pll_a_clk),
    .ext_voice_clk (ext_voice_clk),
    .pll_b_clk     (pll_b_clk),
    .div_clk       (voice_div_clk),
    .pad_func      ({func_b, func_a}),
    .hifi_clk      (hifi_clk),
    .voice_clk     (voice_clk),
    .pad_out       (pads)
  );

  acs_frac_div #(.SYNC_STAGES(SYNC_STAGES)) u_div (
    .clk_in  (voice_clk),
    .rst_n   (rst_n),
    .code_in (ctrl.ratio),
    .clk_out (voice_div_clk)
  );

  assign pad_a = pads[0];
  assign pad_b = pads[1];
endmodule

// File: tb/audio_clk_sel_tb.sv
`timescale 1ns/1ps
module audio_clk_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VOICE_NS = 20;
  localparam logic [3:0] CTRL_ADDR = 4'h3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic ext_hifi_clk = 0, pll_a_clk = 0, ext_voice_clk = 0, pll_b_clk = 0;
  logic func_a = 0, func_b = 0;
  logic hifi_clk, voice_clk, voice_div_clk, pad_a, pad_b;

  int checks = 0, failures = 0;
  logic m_pad_a = 0, m_pad_b = 0;
  logic [7:0] lfsr = 8'h5a;

  audio_clk_sel u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always #7  ext_hifi_clk = ~ext_hifi_clk;
  always #9  pll_a_clk = ~pll_a_clk;
  always #(VOICE_NS/2) ext_voice_clk = ~ext_voice_clk;
  always #15 pll_b_clk = ~pll_b_clk;

  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    func_a <= lfsr[0];
    func_b <= lfsr[3];
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Per-cycle model of the pads in GPIO mode (R9, R1)
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (!m_pad_a) chk("R9 pad_a gpio", pad_a, func_a);
      if (!m_pad_b) chk("R9 pad_b gpio", pad_b, func_b);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (a == CTRL_ADDR) begin m_pad_a = d[6]; m_pad_b = d[7]; end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_rise(input int s);
    case (s)
      0: @(posedge hifi_clk);
      1: @(posedge voice_clk);
      2: @(posedge voice_div_clk);
      3: @(posedge pad_a);
      default: @(posedge pad_b);
    endcase
  endtask

  task automatic wait_fall(input int s);
    case (s)
      0: @(negedge hifi_clk);
      1: @(negedge voice_clk);
      2: @(negedge voice_div_clk);
      3: @(negedge pad_a);
      default: @(negedge pad_b);
    endcase
  endtask

  task automatic get_period(input int s, output longint p);
    longint t0;
    repeat (4) wait_rise(s);
    t0 = $time;
    wait_rise(s);
    p = $time - t0;
  endtask

  task automatic get_high(input int s, output longint h);
    longint t0;
    wait_rise(s);
    t0 = $time;
    wait_fall(s);
    h = $time - t0;
  endtask

  // share=0, voice from ext_voice_clk (20 ns), given ratio code
  task automatic div_case(input logic [2:0] code, input int exp_cyc,
                          input longint exp_high, input string req);
    longint p, h;
    wr(CTRL_ADDR, {5'b00000, code});
    get_period(2, p);
    chk({req, " period cycles"}, p / VOICE_NS, exp_cyc);
    get_high(2, h);
    chk({req, " high ns"}, h, exp_high);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint p, h;
    longint pr [5];
    longint hs [2];
    longint hi_w, lo_w, t0, t1;
    #43 rst_n = 1;

    // R1 reset state
    get_period(0, p); chk("R1 hifi from ext pin", p, 14);
    get_period(1, p); chk("R1 voice shares hifi", p, 14);
    get_period(2, p); chk("R1 divider bypassed", p, 14);

    // R2 write to a foreign address ignored
    wr(4'h5, 8'b0000_1000);
    get_period(0, p); chk("R2 foreign address ignored", p, 14);

    // R3 hifi from PLL A, R4 share
    wr(CTRL_ADDR, 8'b0010_1000);
    get_period(0, p); chk("R3 hifi from pll_a", p, 18);
    get_period(1, p); chk("R4 voice shares hifi pll", p, 18);

    // R4 own voice from PLL B
    wr(CTRL_ADDR, 8'b0001_1000);
    get_period(1, p); chk("R4 voice from pll_b", p, 30);
    get_period(0, p); chk("R3 hifi stays pll_a", p, 18);
    wr(CTRL_ADDR, 8'b0000_0000);
    get_period(1, p); chk("R4 voice from ext pin", p, 20);
    get_period(0, p); chk("R3 hifi from ext pin", p, 14);

    // R5 / R6 integer ratios
    div_case(3'b000, 1, 10, "R5 code000");
    div_case(3'b001, 1, 10, "R5 code001");
    div_case(3'b100, 2, 20, "R6 code100");
    div_case(3'b010, 3, 20, "R6 code010");
    div_case(3'b101, 4, 40, "R6 code101");
    div_case(3'b110, 6, 60, "R6 code110");
    div_case(3'b111, 8, 80, "R6 code111");

    // R7 ratio 5.5
    wr(CTRL_ADDR, 8'b0000_0011);
    repeat (4) wait_rise(2);
    for (int i = 0; i < 5; i++) begin
      wait_rise(2);
      pr[i] = $time;
    end
    for (int i = 0; i < 3; i++) begin
      longint a, b;
      a = (pr[i+1] - pr[i]) / VOICE_NS;
      b = (pr[i+2] - pr[i+1]) / VOICE_NS;
      chk("R7 pair sum", a + b, 11);
      chk("R7 period is 5 or 6", (a == 5 || a == 6) ? 1 : 0, 1);
    end
    for (int i = 0; i < 2; i++) get_high(2, hs[i]);
    chk("R7 high pair sum", hs[0] + hs[1], 100);
    chk("R7 high is 40 or 60", (hs[0] == 40 || hs[0] == 60) ? 1 : 0, 1);

    // R8 ratio change from 8 to 2 at a period boundary
    wr(CTRL_ADDR, 8'b0000_0111);
    repeat (4) wait_rise(2);
    wr(CTRL_ADDR, 8'b0000_0100);
    wait_rise(2);
    t0 = $time;
    hi_w = 0;
    for (int i = 0; i < 10; i++) begin
      wait_fall(2);
      t1 = $time;
      hi_w = t1 - t0;
      wait_rise(2);
      t0 = $time;
      lo_w = t0 - t1;
      chk("R8 high width old or new", (hi_w == 80 || hi_w == 20) ? 1 : 0, 1);
      chk("R8 low width old or new", (lo_w == 80 || lo_w == 20) ? 1 : 0, 1);
    end
    chk("R8 new ratio reached", hi_w, 20);

    // R9 pads carry clocks
    wr(CTRL_ADDR, 8'b1100_0100);
    get_period(3, p); chk("R9 pad_a hifi clock", p, 14);
    get_period(4, p); chk("R9 pad_b divided clock", p, 40);
    wr(CTRL_ADDR, 8'b0000_0000);
    repeat (20) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule